// File: doc/BRIEF.md
# Erasable One-Time-Writable Byte Memory

This block is a synthesizable, clocked model of a byte-wide memory whose cells start at one and can only be cleared by writing. It does not see supply levels. It sees two active-low enables (chip select and output gate) and two flags: one says the write supply is raised, the other says the identification voltage is on the address line. From these four it decodes an operating mode once per rising clock edge. Depending on the mode, it shows a stored byte, shows nothing, clears bits at the addressed location, or shows one of two fixed identifier bytes.

High impedance is modelled as a drive-enable output beside the data bus. While the drive enable is low, the data bus is held at zero. A one-cycle `erase` input returns every location to all ones, and reset does the same.

The decoded mode is held in a state register `state_q`, which has seven named states:
- `M_STANDBY`: chip select high, write supply normal.
- `M_READ`: both enables low, write supply and identification flag off.
- `M_OFF`: chip select low, output gate high, write supply normal.
- `M_PROG`: write supply high, chip select low, output gate high.
- `M_VERIFY`: write supply high, chip select high, output gate low.
- `M_INHIBIT`: write supply high and both enables equal.
- `M_SIGN`: identification flag on, write supply normal, both enables low.

Every edge moves `state_q` to the mode decoded from the inputs sampled at that edge, so any state can follow any other. The outputs are a function of `state_q` and of a data byte captured at the same edge.

Top module: `eprom_model`

## Requirements
- R1: Reset clears `q_en`, `q_data` and `sig_err` to zero and fills every location with 0xFF.
- R2: If `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `id_hi`=0 are sampled at an edge, then after that edge `q_en`=1 and `q_data` is the byte stored at `addr`.
- R3: If `ce_n`=1 and `vpp_hi`=0 are sampled at an edge, then after that edge `q_en`=0 and `q_data`=0, whatever `oe_n` is.
- R4: If `ce_n`=0, `oe_n`=1 and `vpp_hi`=0 are sampled at an edge, then after that edge `q_en`=0 and `q_data`=0.
- R5: If `vpp_hi`=1, `ce_n`=0 and `oe_n`=1 are sampled at an edge, the location at `addr` becomes its old value AND `din`, and the outputs are not driven. No bit can go from 0 to 1 through this path.
- R6: If `vpp_hi`=1, `ce_n`=1 and `oe_n`=0 are sampled at an edge, then after that edge `q_en`=1 and `q_data` is the byte stored at `addr`.
- R7: If `vpp_hi`=1 and `ce_n`=`oe_n` are sampled at an edge, no location changes and the outputs are not driven.
- R8: If `vpp_hi`=0, `id_hi`=1, `ce_n`=0 and `oe_n`=0 are sampled at an edge, then after that edge `q_en`=1 and `q_data` is 0x20 when `addr[0]`=0 and 0x8D when `addr[0]`=1. The array contents play no part.
- R9: In the mode of R8, `sig_err`=1 when any address bit other than bit 0 and bit 9 is set. In every other mode `sig_err`=0.
- R10: When `erase`=1 is sampled at an edge, every location reads 0xFF from the next edge on. This takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| vpp_hi | input | 1 | Write supply is raised |
| id_hi | input | 1 | Identification voltage is present on the address line |
| erase | input | 1 | One-cycle request to set all bits to one |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to be written |
| q_en | output | 1 | Data bus is driven (0 models high impedance) |
| q_data | output | 8 | Output byte, zero when not driven |
| sig_err | output | 1 | Identifier read with stray address bits set |

## Verification
Some behaviours are checked by assertions on every cycle:
- In both normal-supply quiet modes, the drive enable is low one edge after those inputs are sampled.
- A write never raises a bit.
- An erase leaves the addressed byte at 0xFF on the next edge.
- The low identifier byte appears whenever it is selected.
- The error flag only rises while the identifier is being driven.

Other behaviours only the bench scenarios can show. These need a reference image of the whole array: the AND accumulation over repeated writes to one address, the fact that inhibited cycles leave data untouched, and erase winning over a write in the same cycle.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_READ,
        M_OFF,
        M_PROG,
        M_VERIFY,
        M_INHIBIT,
        M_SIGN
    } mode_e;

    localparam logic [BYTE_W-1:0] ID_LOW  = 8'h20;
    localparam logic [BYTE_W-1:0] ID_HIGH = 8'h8D;
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  vpp_hi,
    input  logic  id_hi,
    output mode_e mode
);
    always_comb begin
        if (vpp_hi) begin
            if (!ce_n && oe_n)      mode = M_PROG;
            else if (ce_n && !oe_n) mode = M_VERIFY;
            else                    mode = M_INHIBIT;
        end else if (ce_n) begin
            mode = M_STANDBY;
        end else if (oe_n) begin
            mode = M_OFF;
        end else if (id_hi) begin
            mode = M_SIGN;
        end else begin
            mode = M_READ;
        end
    end
endmodule

// File: rtl/eprom_array.sv
module eprom_array
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    assign rd_data = mem[addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr) begin
            mem[addr] <= mem[addr] & din;
        end
    end

    AST_WRITE_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !erase) |=> ((mem[$past(addr)] & ~$past(rd_data)) == '0)); // R5

    AST_ERASE_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (rd_data == '1)); // R10
endmodule

// File: rtl/eprom_id_rom.sv
module eprom_id_rom
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int ID_BIT = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] id_byte,
    output logic              stray
);
    localparam logic [ADDR_W-1:0] KEEP_MASK = ADDR_W'(1) | (ADDR_W'(1) << ID_BIT);

    assign id_byte = addr[0] ? ID_HIGH : ID_LOW;
    assign stray   = |(addr & ~KEEP_MASK);
endmodule

// File: rtl/eprom_model.sv
module eprom_model
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int ID_BIT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              id_hi,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              q_en,
    output logic [7:0]        q_data,
    output logic              sig_err
);
    mode_e             mode_d;
    mode_e             state_q;
    logic [BYTE_W-1:0] rd_data;
    logic [BYTE_W-1:0] id_byte;
    logic              stray;
    logic [BYTE_W-1:0] data_q;
    logic              stray_q;

    eprom_mode_dec u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_hi (vpp_hi),
        .id_hi  (id_hi),
        .mode   (mode_d)
    );

    eprom_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (erase),
        .wr      (mode_d == M_PROG),
        .addr    (addr),
        .din     (din),
        .rd_data (rd_data)
    );

    eprom_id_rom #(.ADDR_W(ADDR_W), .ID_BIT(ID_BIT)) u_id (
        .addr    (addr),
        .id_byte (id_byte),
        .stray   (stray)
    );

    // State register plus the byte captured for the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= M_STANDBY;
            data_q  <= '0;
            stray_q <= 1'b0;
        end else begin
            state_q <= mode_d;
            unique case (mode_d)
                M_READ, M_VERIFY: begin
                    data_q  <= rd_data;
                    stray_q <= 1'b0;
                end
                M_SIGN: begin
                    data_q  <= id_byte;
                    stray_q <= stray;
                end
                default: begin
                    data_q  <= '0;
                    stray_q <= 1'b0;
                end
            endcase
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        unique case (state_q)
            M_READ, M_VERIFY: begin
                q_en    = 1'b1;
                q_data  = data_q;
                sig_err = 1'b0;
            end
            M_SIGN: begin
                q_en    = 1'b1;
                q_data  = data_q;
                sig_err = stray_q;
            end
            default: begin
                q_en    = 1'b0;
                q_data  = '0;
                sig_err = 1'b0;
            end
        endcase
    end

    AST_STANDBY_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n && !vpp_hi) |-> !q_en); // R3

    AST_GATE_OFF_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ce_n && oe_n && !vpp_hi) |-> !q_en); // R4

    AST_ID_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!vpp_hi && id_hi && !ce_n && !oe_n && !addr[0]) |-> (q_en && q_data == 8'h20)); // R8

    AST_ERR_ONLY_ON_ID: assert property (@(posedge clk) disable iff (!rst_n)
        sig_err |-> (q_en && $past(id_hi && !vpp_hi))); // R9
endmodule

// File: tb/test_eprom_model.sv
module test_eprom_model;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, id_hi = 1'b0, erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic          q_en, sig_err;
    logic [7:0]    q_data;

    logic [7:0] ref_mem [DEPTH];
    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    eprom_model #(.ADDR_W(AW)) i_eprom_model (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
        .id_hi(id_hi), .erase(erase), .addr(addr), .din(din),
        .q_en(q_en), .q_data(q_data), .sig_err(sig_err)
    );

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got en/err/data=%b/%b/%h expected %b/%b/%h", tag,
                     act[9], act[8], act[7:0], exp[9], exp[8], exp[7:0]);
        end
    endtask

    function automatic string mode_tag(input logic c, input logic o, input logic v, input logic i);
        if (v) return (!c && o) ? "R5" : ((c && !o) ? "R6" : "R7");
        if (c) return "R3";
        if (o) return "R4";
        return i ? "R8" : "R2";
    endfunction

    // Called at a falling edge: applies inputs, predicts, steps one edge, checks.
    task automatic cyc(input logic c, input logic o, input logic v, input logic i,
                       input logic [AW-1:0] a, input logic [7:0] d, input logic er,
                       input string tag);
        logic       e_en, e_err;
        logic [7:0] e_dat;
        ce_n = c; oe_n = o; vpp_hi = v; id_hi = i; addr = a; din = d; erase = er;
        e_en = 1'b0; e_err = 1'b0; e_dat = 8'h00;
        if (!v && !c && !o) begin
            e_en = 1'b1;
            if (i) begin
                e_dat = a[0] ? 8'h8D : 8'h20;
                for (int b = 1; b < AW; b++) if (b != 9 && a[b]) e_err = 1'b1;
            end else e_dat = ref_mem[a];
        end else if (v && c && !o) begin
            e_en = 1'b1;
            e_dat = ref_mem[a];
        end
        if (er) begin
            for (int k = 0; k < DEPTH; k++) ref_mem[k] = 8'hFF;
        end else if (v && !c && o) begin
            ref_mem[a] = ref_mem[a] & d;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, {q_en, sig_err, q_data}, {e_en, e_err, e_dat});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic c, o, v, i, er;
        logic [AW-1:0] a;
        for (int k = 0; k < DEPTH; k++) ref_mem[k] = 8'hFF;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", {q_en, sig_err, q_data}, 10'b0);
        cyc(0, 0, 0, 0, 10'd5,   8'h00, 0, "R1");
        cyc(0, 0, 0, 0, 10'd900, 8'h00, 0, "R1");
        cyc(0, 1, 1, 0, 10'd5,   8'hA5, 0, "R5");
        cyc(1, 0, 1, 0, 10'd5,   8'h00, 0, "R6");
        cyc(0, 1, 1, 0, 10'd5,   8'h5A, 0, "R5");
        cyc(0, 0, 0, 0, 10'd5,   8'h00, 0, "R5");
        cyc(1, 0, 0, 0, 10'd5,   8'h00, 0, "R3");
        cyc(1, 1, 0, 0, 10'd5,   8'h00, 0, "R3");
        cyc(0, 1, 0, 0, 10'd5,   8'h00, 0, "R4");
        cyc(1, 1, 1, 0, 10'd6,   8'h00, 0, "R7");
        cyc(0, 0, 1, 0, 10'd6,   8'h00, 0, "R7");
        cyc(0, 0, 0, 0, 10'd6,   8'h00, 0, "R7");
        cyc(0, 0, 0, 1, 10'd0,   8'h00, 0, "R8");
        cyc(0, 0, 0, 1, 10'd1,   8'h00, 0, "R8");
        cyc(0, 0, 0, 1, 10'h201, 8'h00, 0, "R9");
        cyc(0, 0, 0, 1, 10'h008, 8'h00, 0, "R9");
        cyc(0, 1, 1, 0, 10'd7,   8'h00, 1, "R10");
        cyc(0, 0, 0, 0, 10'd7,   8'h00, 0, "R10");
        cyc(0, 0, 0, 0, 10'd5,   8'h00, 0, "R10");
        for (int n = 0; n < 4000; n++) begin
            c = 1'($urandom); o = 1'($urandom);
            v = ($urandom % 3) == 0; i = ($urandom % 5) == 0;
            er = ($urandom % 400) == 0;
            a = (($urandom % 8) == 0) ? AW'($urandom) : AW'($urandom % 16);
            cyc(c, o, v, i, a, 8'($urandom), er, er ? "R10" : mode_tag(c, o, v, i));
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule